// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block runs on the host side of a byte-wide parallel flash bus. After the host has issued a program or erase command, the flash runs an internal write on its own. The poller is then started with the location that was written and the byte that location should finally hold; for an erase that byte is FFh. It drives chip-select, output-enable and address, and reads the location over and over. It reports completion or a timeout.

Two detection methods can be chosen at start. In data-polling mode, bit 7 of a status read is the inverse of the expected bit 7 while the write is still running. In toggle mode, bit 6 changes value on every read while the write runs. The flash finishes asynchronously to the host, so one read can race with completion and give a misleading value. For this reason, a read that looks finished is only a candidate. The poller reports done only after two further reads of the same location both return the full expected byte.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy, done and fail are 0, and both fl_ce_n and fl_oe_n are high.
- R2: In idle, a start pulse latches the address, the expected byte and the mode (mode 0 = data polling, mode 1 = toggle). It clears done and fail, and raises busy on the next cycle. fl_addr then shows the latched address until the operation ends.
- R3: Each read holds fl_ce_n and fl_oe_n low for exactly RD_CYCLES clocks and samples fl_dq on the last of them. Both strobes go high for one clock between reads, and they stay high while idle.
- R4: In data-polling mode, a read is a candidate when its bit 7 equals bit 7 of the expected byte.
- R5: In toggle mode, a read is a candidate when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation is never a candidate.
- R6: After a candidate, each of the next two reads must equal the whole expected byte. Done is reported at the end of the second of these reads. A mismatch returns the poller to searching, and that read becomes the previous read for toggle comparison.
- R7: If MAX_READS reads complete without done, the poller ends with fail set.
- R8: done and fail are never high together. Whichever was set stays high, with busy low, until the next accepted start.
- R9: A start pulse while busy is ignored. The address and the outcome of the running operation are unchanged.
- R10: When an operation ends after its n-th read, the result is visible n*(RD_CYCLES+1)-1 clock edges after the edge that accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| mode | input | 1 | 0 = inverted-data polling on bit 7, 1 = toggle on bit 6 |
| addr_in | input | AW | Location that was written |
| exp_data | input | 8 | Byte the location should finally hold (FFh after erase) |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Write confirmed complete |
| fail | output | 1 | Read limit reached without completion |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq | input | 8 | Flash data bus |

## Verification
A corrupted confirmation count or previous-bit register shows up at the ports as a different number of output-enable pulses. It also moves done by a whole multiple of RD_CYCLES+1 cycles, so the error is visible when the operation ends. A read that races with completion is modelled as a lone finished-looking wrong byte at each possible position. A poller that trusted it too early would raise done several reads early, or would never drop back to searching. A stuck timer or read counter shows at once in the strobe width, or as fail at a read count other than MAX_READS.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW        = 16,
  parameter int RD_CYCLES = 3,
  parameter int MAX_READS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    exp_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  input  logic [7:0]    fl_dq
);

  localparam int TW = (RD_CYCLES > 1) ? $clog2(RD_CYCLES) : 1;
  localparam int NW = $clog2(MAX_READS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(RD_CYCLES - 1);
  localparam logic [NW-1:0] N_MAX  = NW'(MAX_READS);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_GAP} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [NW-1:0] nrd;
  logic [1:0]    conf;
  logic          have_prev, prev6, m_q;
  logic [AW-1:0] a_q;
  logic [7:0]    x_q;

  logic       sample, cand, match, finish;
  logic [1:0] conf_nx;

  assign sample  = (st == S_RD) && (tmr == T_LAST);
  assign cand    = m_q ? (have_prev && (fl_dq[6] == prev6)) : (fl_dq[7] == x_q[7]);
  assign match   = (fl_dq == x_q);
  assign conf_nx = (conf == 2'd0) ? {1'b0, cand} : (match ? conf + 2'd1 : 2'd0);
  assign finish  = (conf == 2'd2) && match;

  assign busy    = (st != S_IDLE);
  assign fl_ce_n = (st != S_RD);
  assign fl_oe_n = (st != S_RD);
  assign fl_addr = a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      nrd       <= '0;
      conf      <= '0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
      m_q       <= 1'b0;
      a_q       <= '0;
      x_q       <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          a_q       <= addr_in;
          x_q       <= exp_data;
          m_q       <= mode;
          done      <= 1'b0;
          fail      <= 1'b0;
          nrd       <= '0;
          conf      <= '0;
          have_prev <= 1'b0;
          tmr       <= '0;
          st        <= S_RD;
        end
        S_RD: if (sample) begin
          tmr       <= '0;
          nrd       <= nrd + 1'b1;
          prev6     <= fl_dq[6];
          have_prev <= 1'b1;
          conf      <= conf_nx;
          if (finish) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (nrd + 1'b1 == N_MAX) begin
            fail <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_GAP;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: st <= S_RD;
      endcase
    end
  end

  // R8
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail));
  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe_n) |-> $past(tmr) == T_LAST);
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_oe_n));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fl_addr));
  // R6
  min_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> nrd >= NW'(3));
  // R7
  fail_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> nrd == N_MAX);

endmodule

// File: tb/test_flash_done_poller.sv
`timescale 1ns/1ps
module test_flash_done_poller;
  localparam int AW = 16, RD = 2, MAXR = 14;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] exp_data = '0;
  logic busy, done, fail, fl_ce_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq;

  int checks = 0, fails = 0;
  int k = 0;
  logic [7:0] script [32];
  logic [7:0] cur_exp;

  always #5 clk = ~clk;

  flash_done_poller #(.AW(AW), .RD_CYCLES(RD), .MAX_READS(MAXR)) i_flash_done_poller (
    .clk, .rst_n, .start, .mode, .addr_in, .exp_data, .busy, .done, .fail,
    .fl_ce_n, .fl_oe_n, .fl_addr, .fl_dq);

  assign fl_dq = (k < 32) ? script[k] : cur_exp;
  always @(posedge fl_oe_n) k = k + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference outcome from the requirement rules (R4..R7)
  function automatic void ref_walk(input bit m, input logic [7:0] x,
                                   output int n, output bit ok);
    int conf = 0;
    bit hp = 0, p6 = 0;
    ok = 0;
    n = MAXR;
    for (int r = 1; r <= MAXR; r++) begin
      logic [7:0] v = (r - 1 < 32) ? script[r-1] : x;
      if (conf == 0) begin
        if (m ? (hp && v[6] == p6) : (v[7] == x[7])) conf = 1;
      end else if (v == x) begin
        conf++;
        if (conf == 3) begin ok = 1; n = r; end
      end else conf = 0;
      p6 = v[6];
      hp = 1;
      if (ok) break;
    end
  endfunction

  task automatic run(input bit m, input logic [7:0] x, input int b, input int g,
                     input logic [AW-1:0] a);
    int n, cyc;
    bit ok, addr_bad;
    for (int i = 0; i < 32; i++) begin
      if (i < b) begin
        if (i == g) script[i] = m ? {~x[7], (i == 0) ? 1'b0 : 1'(i - 1), ~x[5:0]}
                                  : {x[7], ~x[6:0]};
        else script[i] = m ? {1'b0, 1'(i), 6'b101010} : {~x[7], 1'(i), 6'b010101};
      end else script[i] = x;
    end
    cur_exp = x;
    ref_walk(m, x, n, ok);
    @(negedge clk);
    k = 0;
    start = 1'b1; mode = m; exp_data = x; addr_in = a;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    addr_bad = 0;
    while (!done && !fail && cyc < 500) begin
      if (fl_addr !== a) addr_bad = 1;
      if (cyc == 3) begin start = 1'b1; addr_in = ~a; mode = ~m; exp_data = ~x; end
      else start = 1'b0;
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == ok, "R6 done", done, ok);
    chk(fail == !ok, "R7 fail", fail, !ok);
    chk(k == n, "R3 read count", k, n);
    chk(cyc == n * (RD + 1) - 1, "R10 latency", cyc, n * (RD + 1) - 1);
    chk(!addr_bad, "R9 addr held across start while busy", addr_bad, 0);
    repeat (3) @(negedge clk);
    chk(!busy && fl_oe_n && fl_ce_n && (done == ok) && (fail == !ok) && k == n,
        "R8 result held, bus idle", {busy, fl_oe_n, done, fail}, {1'b0, 1'b1, ok, !ok});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) script[i] = 8'h00;
    cur_exp = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail && fl_ce_n && fl_oe_n, "R1 reset",
        {busy, done, fail, fl_ce_n, fl_oe_n}, 5'b00011);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 start latches and raises busy; R3 strobes low immediately
    start = 1'b1; addr_in = 16'h2A55; mode = 1'b0; exp_data = 8'hFF;
    for (int i = 0; i < 32; i++) script[i] = 8'hFF;
    cur_exp = 8'hFF;
    k = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy && fl_addr == 16'h2A55 && !fl_oe_n && !fl_ce_n, "R2 start accepted",
        {busy, fl_oe_n}, 2'b10);
    @(negedge clk);
    chk(!fl_oe_n, "R3 strobe still low", fl_oe_n, 0);
    @(negedge clk);
    chk(fl_oe_n && fl_ce_n, "R3 gap between reads", fl_oe_n, 1);
    while (busy) @(negedge clk);
    chk(done && k == 3, "R4 erase confirm in three reads", k, 3);
    // sweep: R4/R5/R6 races at every position, both modes
    for (int m = 0; m < 2; m++)
      for (int b = 0; b <= 6; b++)
        for (int g = -1; g < b; g++)
          run(1'(m), (b == 3) ? 8'hFF : (8'h93 ^ 8'(b * 17)), b, g, 16'(16'h1000 + b * 16 + g + 1));
    // R7 timeout in both modes
    run(1'b0, 8'h5A, 30, -1, 16'h0F0F);
    run(1'b1, 8'hA5, 30, -1, 16'h7777);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule